// File: doc/BRIEF.md
# Link Receiver Configuration Target

This block is a target on a two-wire serial control bus, compatible with I2C, that holds four 8-bit configuration registers for a serial link receiver. It runs on the system clock and oversamples the bus clock and data lines through two-flop synchronisers. It detects START, repeated START and STOP conditions, matches a 7-bit device address, and acknowledges. It supports single-byte and sequential reads and writes through an internal register pointer that advances after each byte.

The configuration fields the receiver uses come from strap pins by default. When register 0 bit 0 is set, the register fields replace the straps. The device address comes from a 2-bit strap selection unless register 1 bit 7 selects the register-held address. A power-down input returns every register to its reset value. The sleep bit only reports a low-power request and leaves the register contents alone. After reset, and again after power-down is released, the target ignores the bus for a programmable number of system clocks.

The block has no data stream, so it has no valid/ready interface. The bus pins are plain: `sda_oe` high means the target pulls the data line low.

Top module: `lrx_cfg_target`

## Requirements
- R1: After reset, the target neither acknowledges nor changes any register until STARTUP_CYCLES system clocks have passed.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START in any state, including a repeated START in the middle of a write, restarts address reception. After a STOP the target releases SDA.
- R3: With the register address source off, strap values 0, 1, 2 and 3 select the addresses 0x71, 0x72, 0x73 and 0x76. A matching address byte is acknowledged by pulling SDA low during the ninth clock. For any other address the target does not drive SDA for the rest of the transaction, and the writes in that transaction change nothing.
- R4: When register 1 bit 7 is 1, the address is register 1 bits 6:0, and the strap address is no longer acknowledged.
- R5: In a write (R/W bit 0), the first data byte loads the register pointer from its two low bits. Each following byte is stored at the pointer, after which the pointer advances modulo 4. Every data byte is acknowledged.
- R6: In a read (R/W bit 1), bytes are sent MSB first from the pointer, and the pointer advances modulo 4 after each byte. A master ACK requests the next byte. A master NACK ends the read and leaves SDA released.
- R7: Reset values are 0x00 for registers 0, 2 and 3 and 0x70 for register 1. All 8 bits of every register read back as written.
- R8: Each configuration output takes the pin image when register 0 bit 0 is 0 and the register of the same index when it is 1, then ANDs it with a fixed mask. The masks are 0xCC for output 0 (bits 7, 6, 3:2), 0xCF for output 2 (bits 7:6, 3:0) and 0xF7 for output 3 (bits 7:4, 2:0). Masked bits read as 0.
- R9: `cfg_sleep` equals register 0 bit 1 whatever the override bit is. Setting it leaves every register value unchanged.
- R10: While `pdn` is high, all registers take their reset values and SDA is released. After `pdn` falls, the start-up delay of R1 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down; resets the registers and holds the bus idle |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| strap_id | input | 2 | Address strap selection |
| strap_ctl | input | 8 | Pin image for configuration output 0 |
| strap_out | input | 8 | Pin image for configuration output 2 |
| strap_rx | input | 8 | Pin image for configuration output 3 |
| cfg_ctl | output | 8 | Masked configuration 0 (SSC range, map select, mode) |
| cfg_sleep | output | 1 | Sleep request, register 0 bit 1 |
| cfg_out | output | 8 | Masked configuration 2 (output enable, idle state, swing, oscillator) |
| cfg_rx | output | 8 | Masked configuration 3 (EQ gain and enable, SSC select) |

## Verification
A wrong pointer or a wrong register value appears on the data line as the wrong byte in the next read, and on the configuration outputs in the cycle after the write's eighth bit once override is on. A bus state machine that drifts out of step with the bit count shows as a missing or misplaced acknowledge within the same byte. Because of this, every write is followed by a full four-register readback. A start-up counter or address decoder that has gone wrong shows as an acknowledge where none is allowed, on the ninth clock of the address byte itself.

// File: rtl/lrx_cfg_pkg.sv
package lrx_cfg_pkg;

  localparam int NUM_REGS = 4;
  localparam int PTR_W    = $clog2(NUM_REGS);

  localparam logic [6:0] ID_RESET  = 7'h70;
  localparam logic [7:0] MASK_CTL  = 8'hCC;
  localparam logic [7:0] MASK_OUT  = 8'hCF;
  localparam logic [7:0] MASK_RX   = 8'hF7;

  typedef enum logic [2:0] {
    BS_IDLE, BS_ADDR, BS_AACK, BS_WDATA, BS_WACK, BS_RDATA, BS_RACK
  } bus_state_t;

  function automatic logic [6:0] strap_addr(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'h71;
      2'd1:    return 7'h72;
      2'd2:    return 7'h73;
      default: return 7'h76;
    endcase
  endfunction

  function automatic logic [7:0] reg_reset(input int idx);
    return (idx == 1) ? {1'b0, ID_RESET} : 8'h00;
  endfunction

endpackage

// File: rtl/lrx_cfg_sync.sv
module lrx_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lrx_cfg_bus.sv
module lrx_cfg_bus
  import lrx_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl,
  input  logic       sda,
  input  logic [6:0] my_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_is_ptr,
  output logic [7:0] wr_data,
  output logic       rd_stb
);
  bus_state_t state;
  logic       scl_q, sda_q;
  logic [7:0] rx_sh, tx_sh;
  logic [3:0] bit_cnt;
  logic       rw, first, mack;

  logic start_c, stop_c, scl_rise, scl_fall;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BS_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      rx_sh <= '0; tx_sh <= '0; bit_cnt <= '0;
      rw <= 1'b0; first <= 1'b0; mack <= 1'b0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_is_ptr <= 1'b0;
      wr_data <= '0; rd_stb <= 1'b0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (!enable) begin
        state  <= BS_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        state   <= BS_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_c) begin
        state  <= BS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          BS_IDLE: ;
          BS_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (rx_sh[7:1] == my_addr) begin
                rw     <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= BS_AACK;
              end else begin
                state <= BS_IDLE;
              end
            end
          end
          BS_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx_sh   <= {rd_data[6:0], 1'b0};
                sda_oe  <= ~rd_data[7];
                rd_stb  <= 1'b1;
                bit_cnt <= 4'd1;
                state   <= BS_RDATA;
              end else begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                first   <= 1'b1;
                state   <= BS_WDATA;
              end
            end
          end
          BS_WDATA: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              wr_stb    <= 1'b1;
              wr_data   <= rx_sh;
              wr_is_ptr <= first;
              first     <= 1'b0;
              sda_oe    <= 1'b1;
              state     <= BS_WACK;
            end
          end
          BS_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= BS_WDATA;
            end
          end
          BS_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= BS_RACK;
              end else begin
                sda_oe  <= ~tx_sh[7];
                tx_sh   <= {tx_sh[6:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          BS_RACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sh   <= {rd_data[6:0], 1'b0};
                sda_oe  <= ~rd_data[7];
                rd_stb  <= 1'b1;
                bit_cnt <= 4'd1;
                state   <= BS_RDATA;
              end else begin
                state <= BS_IDLE;
              end
            end
          end
          default: state <= BS_IDLE;
        endcase
      end
    end
  end

  // R2: a STOP always leaves the data line released
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && enable) |=> !sda_oe);

  // R3: the target only moves SDA while SCL is low
  a_r3_oe_moves_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl || $past(!enable)));
endmodule

// File: rtl/lrx_cfg_regs.sv
module lrx_cfg_regs
  import lrx_cfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pdn,
  input  logic                        wr_stb,
  input  logic                        wr_is_ptr,
  input  logic [7:0]                  wr_data,
  input  logic                        rd_stb,
  output logic [7:0]                  rd_data,
  output logic [NUM_REGS-1:0][7:0]    regs_q
);
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_reset(i);
    end else if (pdn) begin
      ptr <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_reset(i);
    end else if (wr_stb) begin
      if (wr_is_ptr) begin
        ptr <= wr_data[PTR_W-1:0];
      end else begin
        regs_q[ptr] <= wr_data;
        ptr         <= ptr + 1'b1;
      end
    end else if (rd_stb) begin
      ptr <= ptr + 1'b1;
    end
  end

  assign rd_data = regs_q[ptr];

  // R10: one cycle after power-down the file holds its reset image
  a_r10_pdn_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pdn) |-> (regs_q[0] == 8'h00 && regs_q[1] == {1'b0, ID_RESET} &&
                    regs_q[2] == 8'h00 && regs_q[3] == 8'h00));

  // R5: a stored data byte moves the pointer by one, modulo the file size
  a_r5_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_is_ptr && !pdn) |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/lrx_cfg_target.sv
module lrx_cfg_target
  import lrx_cfg_pkg::*;
#(
  parameter int STARTUP_CYCLES = 500000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_id,
  input  logic [7:0] strap_ctl,
  input  logic [7:0] strap_out,
  input  logic [7:0] strap_rx,
  output logic [7:0] cfg_ctl,
  output logic       cfg_sleep,
  output logic [7:0] cfg_out,
  output logic [7:0] cfg_rx
);
  localparam int CW = $clog2(STARTUP_CYCLES + 1);

  logic scl_s, sda_s;
  lrx_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  lrx_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  logic [CW-1:0] boot_cnt;
  logic          ready;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_cnt <= '0;
      ready    <= 1'b0;
    end else if (pdn) begin
      boot_cnt <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      if (boot_cnt == CW'(STARTUP_CYCLES - 1)) ready <= 1'b1;
      else                                     boot_cnt <= boot_cnt + 1'b1;
    end
  end

  logic                     wr_stb, wr_is_ptr, rd_stb;
  logic [7:0]               wr_data, rd_data;
  logic [NUM_REGS-1:0][7:0] regs_q;
  logic [6:0]               my_addr;

  assign my_addr = regs_q[1][7] ? regs_q[1][6:0] : strap_addr(strap_id);

  lrx_cfg_bus u_bus (
    .clk(clk), .rst_n(rst_n), .enable(ready), .scl(scl_s), .sda(sda_s),
    .my_addr(my_addr), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_is_ptr(wr_is_ptr), .wr_data(wr_data), .rd_stb(rd_stb)
  );

  lrx_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .wr_stb(wr_stb), .wr_is_ptr(wr_is_ptr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .regs_q(regs_q)
  );

  logic ovr;
  assign ovr       = regs_q[0][0];
  assign cfg_ctl   = (ovr ? regs_q[0] : strap_ctl) & MASK_CTL;
  assign cfg_out   = (ovr ? regs_q[2] : strap_out) & MASK_OUT;
  assign cfg_rx    = (ovr ? regs_q[3] : strap_rx)  & MASK_RX;
  assign cfg_sleep = regs_q[0][1];

  // R1: the bus stays silent while the start-up delay runs
  a_r1_silent_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ready) |-> !sda_oe);
endmodule

// File: tb/tb_lrx_cfg_target.sv
module tb_lrx_cfg_target;
  localparam int BOOT = 2000;
  localparam int Q    = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, pdn = 1'b0, scl_m = 1'b1, m_low = 1'b0;
  logic [1:0] strap_id = 2'd0;
  logic [7:0] strap_ctl = 8'h00, strap_out = 8'h00, strap_rx = 8'h00;
  logic       sda_oe, cfg_sleep;
  logic [7:0] cfg_ctl, cfg_out, cfg_rx;
  wire        sda_line = !(sda_oe | m_low);

  lrx_cfg_target #(.STARTUP_CYCLES(BOOT)) dut (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_id(strap_id), .strap_ctl(strap_ctl), .strap_out(strap_out), .strap_rx(strap_rx),
    .cfg_ctl(cfg_ctl), .cfg_sleep(cfg_sleep), .cfg_out(cfg_out), .cfg_rx(cfg_rx)
  );

  int checks = 0, errors = 0;
  logic [7:0] mreg [4];
  logic [7:0] wbuf [5];
  logic [7:0] rbuf [4];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_addr(input logic [1:0] s);
    case (s) 2'd0: return 7'h71; 2'd1: return 7'h72; 2'd2: return 7'h73; default: return 7'h76; endcase
  endfunction

  function automatic logic [7:0] ecfg(input logic [7:0] pin, input logic [7:0] rg, input logic ovr, input logic [7:0] mask);
    return (ovr ? rg : pin) & mask;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_low = 1'b0; scl_m = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask
  task automatic i2c_rstart;
    tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask
  task automatic i2c_stop;
    tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b0; tick(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_low = !d[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
    end
    tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); ack = !sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(2*Q); scl_m = 1'b1; tick(Q); d = {d[6:0], sda_line}; tick(Q); scl_m = 1'b0;
    end
    tick(Q); m_low = mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; m_low = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] a, input int n, output logic aok, output logic dok);
    logic ak;
    i2c_start; wr_byte({a, 1'b0}, ak); aok = ak; dok = 1'b1;
    for (int i = 0; i < n; i++) begin wr_byte(wbuf[i], ak); dok &= ak; end
    i2c_stop;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] p, input int n, output logic aok);
    logic ak;
    i2c_start; wr_byte({a, 1'b0}, ak); aok = ak; wr_byte(p, ak); aok &= ak;
    i2c_rstart; wr_byte({a, 1'b1}, ak); aok &= ak;
    for (int i = 0; i < n; i++) rd_byte(i != n - 1, rbuf[i]);
    i2c_stop;
  endtask

  task automatic model_write(input int n);
    logic [1:0] p;
    p = wbuf[0][1:0];
    for (int i = 1; i < n; i++) begin mreg[p] = wbuf[i]; p = p + 2'd1; end
  endtask

  task automatic model_reset;
    mreg[0] = 8'h00; mreg[1] = 8'h70; mreg[2] = 8'h00; mreg[3] = 8'h00;
  endtask

  task automatic read_all(input logic [6:0] a, input string req);
    logic aok;
    do_read(a, 8'h00, 4, aok);
    chk(req, "readback addr ack", {31'd0, aok}, 32'd1);
    for (int i = 0; i < 4; i++) chk(req, $sformatf("reg%0d readback", i), {24'd0, rbuf[i]}, {24'd0, mreg[i]});
  endtask

  task automatic check_cfg;
    tick(2);
    chk("R8", "cfg_ctl", {24'd0, cfg_ctl}, {24'd0, ecfg(strap_ctl, mreg[0], mreg[0][0], 8'hCC)});
    chk("R8", "cfg_out", {24'd0, cfg_out}, {24'd0, ecfg(strap_out, mreg[2], mreg[0][0], 8'hCF)});
    chk("R8", "cfg_rx",  {24'd0, cfg_rx},  {24'd0, ecfg(strap_rx,  mreg[3], mreg[0][0], 8'hF7)});
    chk("R9", "cfg_sleep", {31'd0, cfg_sleep}, {31'd0, mreg[0][1]});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic aok, dok, ak;
    int n;
    logic [1:0] p;
    void'($urandom(32'd4242));
    model_reset();
    strap_ctl = 8'hFF; strap_out = 8'hFF; strap_rx = 8'hFF;
    tick(10); rst_n = 1'b1; tick(2);
    check_cfg();
    chk("R1", "sda released after reset", {31'd0, sda_oe}, 32'd0);

    wbuf[0] = 8'h02; wbuf[1] = 8'h5A;
    do_write(7'h71, 2, aok, dok);
    chk("R1", "ack during start-up", {31'd0, aok}, 32'd0);
    tick(BOOT);
    read_all(7'h71, "R7");

    wbuf[0] = 8'h02; wbuf[1] = 8'hAA;
    do_write(7'h55, 2, aok, dok);
    chk("R3", "foreign address ack", {31'd0, aok}, 32'd0);
    chk("R3", "foreign data ack", {31'd0, dok}, 32'd0);
    read_all(7'h71, "R3");

    for (int s = 0; s < 4; s++) begin
      strap_id = 2'(s); tick(2);
      wbuf[0] = 8'h00;
      do_write(exp_addr(2'(s)), 1, aok, dok);
      chk("R3", $sformatf("strap %0d own address ack", s), {31'd0, aok}, 32'd1);
      do_write(exp_addr(2'(s + 1)), 1, aok, dok);
      chk("R3", $sformatf("strap %0d other address ack", s), {31'd0, aok}, 32'd0);
    end
    strap_id = 2'd0;

    for (int it = 0; it < 20; it++) begin
      n = 2 + int'($urandom % 4);
      wbuf[0] = 8'($urandom);
      p = wbuf[0][1:0];
      for (int i = 1; i < n; i++) begin
        wbuf[i] = 8'($urandom);
        if (p == 2'd1) wbuf[i][7] = 1'b0;
        p = p + 2'd1;
      end
      do_write(7'h71, n, aok, dok);
      model_write(n);
      chk("R5", "random write acks", {30'd0, aok, dok}, 32'd3);
      read_all(7'h71, "R6");
      strap_ctl = 8'($urandom); strap_out = 8'($urandom); strap_rx = 8'($urandom);
      check_cfg();
    end

    wbuf[0] = 8'h03; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    do_write(7'h71, 3, aok, dok);
    model_write(3);
    chk("R5", "wrap write acks", {30'd0, aok, dok}, 32'd3);
    do_read(7'h71, 8'h03, 2, aok);
    chk("R6", "wrap read byte 0", {24'd0, rbuf[0]}, 32'hA5);
    chk("R6", "wrap read byte 1", {24'd0, rbuf[1]}, 32'h3C);
    check_cfg();

    wbuf[0] = 8'h01; wbuf[1] = 8'hAA;
    do_write(7'h71, 2, aok, dok);
    model_write(2);
    wbuf[0] = 8'h00;
    do_write(7'h71, 1, aok, dok);
    chk("R4", "strap address after switch", {31'd0, aok}, 32'd0);
    do_write(7'h2A, 1, aok, dok);
    chk("R4", "register address ack", {31'd0, aok}, 32'd1);
    read_all(7'h2A, "R4");
    wbuf[0] = 8'h01; wbuf[1] = 8'h70;
    do_write(7'h2A, 2, aok, dok);
    model_write(2);

    wbuf[0] = 8'h00; wbuf[1] = 8'h02;
    do_write(7'h71, 2, aok, dok);
    model_write(2);
    check_cfg();
    read_all(7'h71, "R9");

    i2c_start; wr_byte({7'h71, 1'b0}, ak); wr_byte(8'h02, ak); wr_byte(8'h11, ak);
    i2c_rstart; wr_byte({7'h71, 1'b0}, ak);
    chk("R2", "address ack after repeated START", {31'd0, ak}, 32'd1);
    wr_byte(8'h03, ak); wr_byte(8'h22, ak);
    i2c_stop;
    mreg[2] = 8'h11; mreg[3] = 8'h22;
    chk("R2", "sda after STOP", {31'd0, sda_oe}, 32'd0);
    read_all(7'h71, "R2");

    wbuf[0] = 8'h00; wbuf[1] = 8'hC5;
    do_write(7'h71, 2, aok, dok);
    model_write(2);
    check_cfg();
    pdn = 1'b1; tick(4);
    chk("R10", "sda during power-down", {31'd0, sda_oe}, 32'd0);
    chk("R10", "cfg_ctl back to pins", {24'd0, cfg_ctl}, {24'd0, strap_ctl & 8'hCC});
    pdn = 1'b0;
    model_reset();
    wbuf[0] = 8'h00;
    do_write(7'h71, 1, aok, dok);
    chk("R10", "ack right after power-down", {31'd0, aok}, 32'd0);
    tick(BOOT);
    read_all(7'h71, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule